// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a memory that two independent ports share. Each port has an enable, an address and a write strobe. When both ports are enabled on the same address, the block picks the port that reached that address first as the winner. It pulls an active-low busy flag on the other port and blocks that port's write. The block judges arrival order on rising clock edges. It keeps a copy of each port's enable and address from the previous cycle. A port whose enable and address were already in place on the previous edge arrived earlier than a port whose inputs have just changed.

A mode input picks one of two roles. In master mode the block makes the decision itself and drives both busy flags. In slave mode another arbiter makes the decision. The busy flags arrive as inputs and only gate the writes of their own side. The block's own busy outputs then stay high. Each port's gated write strobe goes to the memory array, which is outside this block.

Top module: `dp_collision_arbiter`

## Requirements
- R1: In master mode, when the two enabled addresses differ, or either port is disabled, both busy outputs are high and each write strobe passes through as `wr_go = en & wr`.
- R2: A port whose enable is low never has its busy output low, even when its address equals the other port's address.
- R3: In master mode, when one port's enable and address were unchanged since the previous rising edge and the other port has just reached the same address, the port that just arrived gets busy low. The earlier port keeps busy high.
- R4: In master mode, when both ports reach the same address with no earlier owner, the right port (B) gets busy low and the left port (A) keeps busy high. No earlier owner means both arrive at the same edge, or neither was stable from the previous edge.
- R5: The two busy outputs are never low together.
- R6: In master mode, a port whose busy output is low has its write strobe output held low.
- R7: Once a loser is chosen, the same port stays busy for as long as the address match continues, even after both ports' inputs have become stable.
- R8: As soon as the match ends, the former loser's busy returns high in that same cycle and its writes pass again. This happens when the winner drops its enable or changes its address.
- R9: In slave mode (`master_mode` = 0), both busy outputs stay high. A low `a_busy_in_n` or `b_busy_in_n` blocks only that side's write strobe.
- R10: In master mode, the busy inputs have no effect on the write strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; arrival order is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1 = decide and drive busy, 0 = take busy from inputs |
| a_en | input | 1 | Left port enable |
| a_addr | input | AW | Left port address |
| a_wr | input | 1 | Left port write request |
| b_en | input | 1 | Right port enable |
| b_addr | input | AW | Right port address |
| b_wr | input | 1 | Right port write request |
| a_busy_in_n | input | 1 | Left busy from an external arbiter (slave mode) |
| b_busy_in_n | input | 1 | Right busy from an external arbiter (slave mode) |
| a_busy_n | output | 1 | Left busy, active low |
| b_busy_n | output | 1 | Right busy, active low |
| a_wr_go | output | 1 | Left write strobe after inhibit |
| b_wr_go | output | 1 | Right write strobe after inhibit |

## Verification
The bench sweeps every pair of left and right addresses of a small 3-bit configuration under three arrival patterns: left first, right first, and both at once. These patterns separate the real order-based decision from a fixed priority, and they separate a matching pair from a mismatched one. Each collision is then held with both sides stable and released by dropping the winner's enable. This shows whether the loser is remembered or recomputed, and whether the release is immediate. A slave-mode sweep over all four busy-input combinations checks that each external flag gates only its own side. A master-mode pass with both busy inputs low checks that they are ignored there.

// File: rtl/dp_collision_arbiter.sv
module dp_collision_arbiter #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_mode,
  input  logic          a_en,
  input  logic [AW-1:0] a_addr,
  input  logic          a_wr,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  input  logic          b_wr,
  input  logic          a_busy_in_n,
  input  logic          b_busy_in_n,
  output logic          a_busy_n,
  output logic          b_busy_n,
  output logic          a_wr_go,
  output logic          b_wr_go
);
  typedef enum logic [1:0] {NOBODY, A_LOSES, B_LOSES} loser_t;

  logic          a_en_q, b_en_q;
  logic [AW-1:0] a_addr_q, b_addr_q;
  loser_t        loser, loser_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_en_q   <= 1'b0;
      b_en_q   <= 1'b0;
      a_addr_q <= '0;
      b_addr_q <= '0;
      loser_q  <= NOBODY;
    end else begin
      a_en_q   <= a_en;
      b_en_q   <= b_en;
      a_addr_q <= a_addr;
      b_addr_q <= b_addr;
      loser_q  <= loser;
    end
  end

  wire match    = a_en && b_en && (a_addr == b_addr);
  wire a_stable = a_en_q && (a_addr_q == a_addr);
  wire b_stable = b_en_q && (b_addr_q == b_addr);

  always_comb begin
    if (!match)                   loser = NOBODY;
    else if (loser_q != NOBODY)   loser = loser_q;
    else if (b_stable && !a_stable) loser = A_LOSES;
    else                          loser = B_LOSES;
  end

  wire a_block = master_mode ? (loser == A_LOSES) : !a_busy_in_n;
  wire b_block = master_mode ? (loser == B_LOSES) : !b_busy_in_n;

  assign a_busy_n = !(master_mode && loser == A_LOSES);
  assign b_busy_n = !(master_mode && loser == B_LOSES);
  assign a_wr_go  = a_en && a_wr && !a_block;
  assign b_wr_go  = b_en && b_wr && !b_block;
endmodule

module dp_collision_arbiter_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master_mode,
  input logic          a_en,
  input logic [AW-1:0] a_addr,
  input logic          a_wr,
  input logic          b_en,
  input logic [AW-1:0] b_addr,
  input logic          b_wr,
  input logic          a_busy_in_n,
  input logic          b_busy_in_n,
  input logic          a_busy_n,
  input logic          b_busy_n,
  input logic          a_wr_go,
  input logic          b_wr_go
);
  logic seen;
  always_ff @(posedge clk) seen <= rst_n;

  wire same = a_en && b_en && (a_addr == b_addr);

  p_no_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !same |-> (a_busy_n && b_busy_n));
  p_idle_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !a_en |-> a_busy_n);
  p_idle_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !b_en |-> b_busy_n);
  p_late_b_r3: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (master_mode && same && $past(a_en) && $past(a_addr) == a_addr && !$past(b_en)) |-> !b_busy_n);
  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_busy_n || b_busy_n));
  p_inhibit_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !a_busy_n) |-> !a_wr_go);
  p_inhibit_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !b_busy_n) |-> !b_wr_go);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (master_mode && $past(master_mode) && same && $past(same) && !$past(b_busy_n)
     && $stable(a_addr) && $stable(b_addr)) |-> !b_busy_n);
  p_slave_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (a_busy_n && b_busy_n && (a_wr_go == (a_en && a_wr && a_busy_in_n))));
  p_master_ign_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && a_busy_n) |-> (a_wr_go == (a_en && a_wr)));
endmodule

bind dp_collision_arbiter dp_collision_arbiter_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
  .a_en(a_en), .a_addr(a_addr), .a_wr(a_wr),
  .b_en(b_en), .b_addr(b_addr), .b_wr(b_wr),
  .a_busy_in_n(a_busy_in_n), .b_busy_in_n(b_busy_in_n),
  .a_busy_n(a_busy_n), .b_busy_n(b_busy_n),
  .a_wr_go(a_wr_go), .b_wr_go(b_wr_go)
);

// File: tb/dp_collision_arbiter_test.sv
module dp_collision_arbiter_test;
  localparam int PERIOD = 10;
  localparam int AW = 3;

  logic clk = 1'b0, rst_n = 1'b0, master_mode = 1'b1;
  logic a_en = 0, a_wr = 0, b_en = 0, b_wr = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic a_busy_in_n = 1, b_busy_in_n = 1;
  logic a_busy_n, b_busy_n, a_wr_go, b_wr_go;
  int runs = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  dp_collision_arbiter #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .a_en(a_en), .a_addr(a_addr), .a_wr(a_wr),
    .b_en(b_en), .b_addr(b_addr), .b_wr(b_wr),
    .a_busy_in_n(a_busy_in_n), .b_busy_in_n(b_busy_in_n),
    .a_busy_n(a_busy_n), .b_busy_n(b_busy_n),
    .a_wr_go(a_wr_go), .b_wr_go(b_wr_go));

  task automatic chk(input logic got, input logic exp, input string what);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", what, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    a_en = 0; b_en = 0; a_wr = 0; b_wr = 0;
    @(negedge clk);
  endtask

  task automatic collide(input int order, input int x, input int y);
    logic m, ea, eb;
    m  = (x == y);
    ea = m && (order == 1);
    eb = m && (order != 1);
    idle();
    if (order == 0) begin
      a_en = 1; a_addr = AW'(x); b_addr = AW'(x); a_wr = 1; #1;
      chk(b_busy_n, 1'b1, "R2 disabled B not busy");
      chk(a_wr_go, 1'b1, "R1 lone A write");
      @(negedge clk);
      b_en = 1; b_addr = AW'(y); b_wr = 1;
    end else if (order == 1) begin
      b_en = 1; b_addr = AW'(y); a_addr = AW'(y); b_wr = 1; #1;
      chk(a_busy_n, 1'b1, "R2 disabled A not busy");
      @(negedge clk);
      a_en = 1; a_addr = AW'(x); a_wr = 1;
    end else begin
      a_en = 1; a_addr = AW'(x); a_wr = 1;
      b_en = 1; b_addr = AW'(y); b_wr = 1;
    end
    #1;
    chk(a_busy_n, !ea, m ? (order == 2 ? "R4 tie A" : "R3 A busy") : "R1 A no match");
    chk(b_busy_n, !eb, m ? (order == 2 ? "R4 tie B" : "R3 B busy") : "R1 B no match");
    chk(!(a_busy_n == 0 && b_busy_n == 0), 1'b1, "R5 exclusive");
    chk(a_wr_go, !ea, "R6 A write gate");
    chk(b_wr_go, !eb, "R6 B write gate");
    if (m) begin
      @(negedge clk); #1;
      chk(a_busy_n, !ea, "R7 hold A");
      chk(b_busy_n, !eb, "R7 hold B");
      @(negedge clk);
      if (ea) b_en = 0; else a_en = 0;
      #1;
      chk(a_busy_n & b_busy_n, 1'b1, "R8 release");
      chk(ea ? a_wr_go : b_wr_go, 1'b1, "R8 loser write passes");
    end
  endtask

  initial begin
    #(PERIOD*200000);
    if (!done) begin
      fails++; runs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk(a_busy_n, 1'b1, "R1 reset A busy high");
    chk(b_busy_n, 1'b1, "R1 reset B busy high");
    chk(a_wr_go | b_wr_go, 1'b0, "R1 reset no writes");

    for (int o = 0; o < 3; o++)
      for (int x = 0; x < (1 << AW); x++)
        for (int y = 0; y < (1 << AW); y++)
          collide(o, x, y);

    // R10: busy inputs ignored in master mode
    idle();
    a_busy_in_n = 0; b_busy_in_n = 0;
    a_en = 1; a_addr = 1; a_wr = 1; b_en = 1; b_addr = 2; b_wr = 1; #1;
    chk(a_wr_go, 1'b1, "R10 A ignores busy in");
    chk(b_wr_go, 1'b1, "R10 B ignores busy in");

    // R9: slave mode
    idle();
    master_mode = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      a_busy_in_n = k[0]; b_busy_in_n = k[1];
      a_en = 1; b_en = 1; a_addr = 5; b_addr = 5; a_wr = 1; b_wr = 1; #1;
      chk(a_busy_n & b_busy_n, 1'b1, "R9 slave outputs high");
      chk(a_wr_go, k[0], "R9 slave A inhibit");
      chk(b_wr_go, k[1], "R9 slave B inhibit");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule